// File: doc/BRIEF.md
# Bus Access Fault Classifier

This block watches each access presented on the system bus and decides whether the access is legal under a fixed memory map and a privilege rule. Every rejected access is classified by cause: a wrong-sized or misaligned transfer, a user-mode write to a guarded area, or an address that decodes into a region where nothing is implemented. One access may match several causes together, and all of them are reported.

The error response is combinational and is returned in the same cycle as the access. One cycle later the block emits a single-cycle fault request toward the processor's exception logic. The cause bits collect in a sticky status register that software clears by writing ones. A fault that arrives while earlier causes are still held sets an extra overflow bit, so software can see that at least one fault record was merged into the current one.

The address map is set entirely by parameters. A code window and a data window each have an implemented size at their low end. The data window also has a guarded area at its base. Above these sits a run of 4 KB peripheral slots. Each slot has its own highest implemented register offset and a flag that marks it as a system slot.

Top module: `bus_fault_classifier`

## Requirements
- R1: A valid access with size code 0 (byte) or 1 (halfword) whose address lies in any peripheral slot sets status bit 0 (size cause).
- R2: A valid access with size code 2 (word) whose address has a nonzero value in bits [1:0] sets status bit 0, wherever the address falls.
- R3: A valid write with the privilege input low, aimed at a slot flagged as system or at the guarded area at the base of the data window, sets status bit 1 (protection cause).
- R4: A read never sets bit 1, and neither does a write with the privilege input high.
- R5: A valid access inside a peripheral slot whose offset within the slot is above that slot's highest implemented register offset sets status bit 2 (unimplemented-address cause).
- R6: A valid access inside the code or data window at or above the implemented size of that window sets status bit 2.
- R7: When one access matches several causes, all of their bits are set together by that access.
- R8: The error output is high in the same cycle as a valid access that matches at least one cause. It is low otherwise, and always low while the valid input is low.
- R9: The fault request output is high for exactly the one cycle that follows each access that drew an error. It is low in the cycle after any other cycle.
- R10: Status bits hold their value until they are cleared. A cycle with the clear strobe high clears exactly the bits set in the clear mask. Causes that arrive in the same cycle are recorded after the clear is applied.
- R11: If a faulting access arrives while the status, after any clear in that cycle, is nonzero, status bit 3 (overflow) is set along with the new causes. If the status would be all-zero, bit 3 stays low.
- R12: After reset the status is zero and the fault request output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | An access is presented this cycle |
| acc_addr_i | input | ADDR_W | Byte address of the access |
| acc_size_i | input | 2 | Transfer size: 0 byte, 1 halfword, 2 word |
| acc_write_i | input | 1 | High for a write, low for a read |
| acc_priv_i | input | 1 | High when the access is privileged |
| acc_err_o | output | 1 | Error response for the current access |
| fault_pulse_o | output | 1 | One-cycle fault request to the processor |
| stat_o | output | 4 | Sticky status: bit0 size, bit1 protection, bit2 unimplemented, bit3 overflow |
| stat_clr_i | input | 1 | Write-one-to-clear strobe for the status |
| stat_clr_mask_i | input | 4 | Status bits to clear when the strobe is high |

## Verification
The bench builds the block with a 16-bit address and a compact map: a 16 KB code window with 12 KB implemented, and a 16 KB data window with 4 KB implemented and a 512-byte guarded base. Four peripheral slots follow, with uneven highest offsets (0x010, 0x7FC, 0x040, 0xFFC), and slots 0 and 2 are flagged as system. With this map, a sweep of every 256-byte step of the whole space reaches every region, including the unmapped space above the slots. Each step is tried with all four low address bits, every size, both directions and both privilege levels, and extra probes sit on each configured edge. Directed sequences then exercise back-to-back faults, partial and full clears in the same cycle as a new fault, and the overflow rule.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  localparam int CAUSE_W  = 3;
  localparam int STAT_W   = 4;
  localparam int C_SIZE   = 0;
  localparam int C_PROT   = 1;
  localparam int C_RSVD   = 2;
  localparam int C_MISS   = 3;
  localparam int SLOT_SZ  = 4096;
  localparam int OFS_W    = 12;

  function automatic logic in_span(input logic [31:0] a,
                                   input int unsigned base,
                                   input int unsigned span);
    return (a >= base) && ((a - base) < span);
  endfunction

  function automatic logic at_or_above(input logic [31:0] a,
                                       input int unsigned base,
                                       input int unsigned span,
                                       input int unsigned impl);
    return in_span(a, base, span) && ((a - base) >= impl);
  endfunction

  function automatic logic [OFS_W-1:0] slot_ofs(input logic [31:0] a,
                                                input int unsigned base);
    logic [31:0] d;
    d = a - base;
    return d[OFS_W-1:0];
  endfunction

endpackage

// File: rtl/bfc_region_decode.sv
module bfc_region_decode
  import bfc_pkg::*;
#(
  parameter int unsigned ADDR_W         = 32,
  parameter int unsigned CODE_BASE      = 32'h0000_0000,
  parameter int unsigned CODE_WIN       = 32'h0010_0000,
  parameter int unsigned CODE_IMPL      = 32'h0004_0000,
  parameter int unsigned DATA_BASE      = 32'h2000_0000,
  parameter int unsigned DATA_WIN       = 32'h0010_0000,
  parameter int unsigned DATA_IMPL      = 32'h0000_4000,
  parameter int unsigned GUARD_BYTES    = 32'h0000_0800,
  parameter int unsigned SLOT_BASE      = 32'h4000_0000,
  parameter int unsigned NUM_SLOT       = 8,
  parameter logic [NUM_SLOT*OFS_W-1:0] SLOT_LAST = {8{12'h0FC}},
  parameter logic [NUM_SLOT-1:0]       SLOT_SYS  = 8'h0F
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              in_slot_o,
  output logic              slot_sys_o,
  output logic              slot_over_o,
  output logic              guard_o,
  output logic              mem_over_o
);

  logic [31:0]         a32;
  logic [NUM_SLOT-1:0] hit_v;
  logic [NUM_SLOT-1:0] sys_v;
  logic [NUM_SLOT-1:0] over_v;

  assign a32 = 32'(addr_i);

  for (genvar i = 0; i < NUM_SLOT; i++) begin : g_slot
    localparam int unsigned SB = SLOT_BASE + i * SLOT_SZ;
    assign hit_v[i]  = in_span(a32, SB, SLOT_SZ);
    assign sys_v[i]  = hit_v[i] && SLOT_SYS[i];
    assign over_v[i] = hit_v[i] && (slot_ofs(a32, SB) > SLOT_LAST[i*OFS_W +: OFS_W]);
  end

  assign in_slot_o   = |hit_v;
  assign slot_sys_o  = |sys_v;
  assign slot_over_o = |over_v;
  assign guard_o     = in_span(a32, DATA_BASE, GUARD_BYTES);
  assign mem_over_o  = at_or_above(a32, CODE_BASE, CODE_WIN, CODE_IMPL) ||
                       at_or_above(a32, DATA_BASE, DATA_WIN, DATA_IMPL);

endmodule

// File: rtl/bfc_cause_eval.sv
module bfc_cause_eval
  import bfc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid_i,
  input  logic [1:0]         size_i,
  input  logic [1:0]         addr_lo_i,
  input  logic               write_i,
  input  logic               priv_i,
  input  logic               in_slot_i,
  input  logic               slot_sys_i,
  input  logic               slot_over_i,
  input  logic               guard_i,
  input  logic               mem_over_i,
  output logic [CAUSE_W-1:0] cause_o
);

  logic sub_word;
  logic word_misalign;
  logic user_write;

  assign sub_word      = (size_i != SZ_WORD);
  assign word_misalign = (size_i == SZ_WORD) && (addr_lo_i != 2'b00);
  assign user_write    = write_i && !priv_i;

  assign cause_o[C_SIZE] = valid_i && ((in_slot_i && sub_word) || word_misalign);
  assign cause_o[C_PROT] = valid_i && user_write && (slot_sys_i || guard_i);
  assign cause_o[C_RSVD] = valid_i && (slot_over_i || mem_over_i);

  // R1: any sub-word access into a slot is flagged
  a_r1_slot_subword: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && in_slot_i && (size_i != SZ_WORD) |-> cause_o[C_SIZE]);

  // R4: reads and privileged writes never draw the protection cause
  a_r4_no_prot: assert property (@(posedge clk) disable iff (!rst_n)
    (!write_i || priv_i) |-> !cause_o[C_PROT]);

  // R5: beyond the last implemented offset of a slot
  a_r5_slot_over: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && slot_over_i |-> cause_o[C_RSVD]);

endmodule

// File: rtl/bfc_status_reg.sv
module bfc_status_reg
  import bfc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic               clr_i,
  input  logic [STAT_W-1:0]  clr_mask_i,
  output logic [STAT_W-1:0]  stat_o,
  output logic               pulse_o
);

  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] kept;
  logic [STAT_W-1:0] stat_d;
  logic              hit;
  logic              pulse_q;

  assign hit    = |cause_i;
  assign kept   = stat_q & ~(clr_i ? clr_mask_i : '0);
  assign stat_d = kept | {hit && (kept != '0), cause_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      stat_q  <= stat_d;
      pulse_q <= hit;
    end
  end

  assign stat_o  = stat_q;
  assign pulse_o = pulse_q;

  // R10: without a clear strobe no status bit falls
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R11: a fault over a nonzero record sets overflow
  a_r11_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    hit && (kept != '0) |=> stat_q[C_MISS]);

  // R11: a fault over an empty record leaves overflow low
  a_r11_clean: assert property (@(posedge clk) disable iff (!rst_n)
    hit && (kept == '0) |=> !stat_q[C_MISS]);

  // R9: the request follows each fault by one cycle
  a_r9_pulse_on: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pulse_q);

  a_r9_pulse_off: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !pulse_q);

endmodule

// File: rtl/bus_fault_classifier.sv
module bus_fault_classifier
  import bfc_pkg::*;
#(
  parameter int unsigned ADDR_W         = 32,
  parameter int unsigned CODE_BASE      = 32'h0000_0000,
  parameter int unsigned CODE_WIN       = 32'h0010_0000,
  parameter int unsigned CODE_IMPL      = 32'h0004_0000,
  parameter int unsigned DATA_BASE      = 32'h2000_0000,
  parameter int unsigned DATA_WIN       = 32'h0010_0000,
  parameter int unsigned DATA_IMPL      = 32'h0000_4000,
  parameter int unsigned GUARD_BYTES    = 32'h0000_0800,
  parameter int unsigned SLOT_BASE      = 32'h4000_0000,
  parameter int unsigned NUM_SLOT       = 8,
  parameter logic [NUM_SLOT*12-1:0] SLOT_LAST = {8{12'h0FC}},
  parameter logic [NUM_SLOT-1:0]    SLOT_SYS  = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [1:0]        acc_size_i,
  input  logic              acc_write_i,
  input  logic              acc_priv_i,
  output logic              acc_err_o,
  output logic              fault_pulse_o,
  output logic [3:0]        stat_o,
  input  logic              stat_clr_i,
  input  logic [3:0]        stat_clr_mask_i
);

  logic               in_slot;
  logic               slot_sys;
  logic               slot_over;
  logic               guard;
  logic               mem_over;
  logic [CAUSE_W-1:0] cause;

  bfc_region_decode #(
    .ADDR_W(ADDR_W), .CODE_BASE(CODE_BASE), .CODE_WIN(CODE_WIN), .CODE_IMPL(CODE_IMPL),
    .DATA_BASE(DATA_BASE), .DATA_WIN(DATA_WIN), .DATA_IMPL(DATA_IMPL),
    .GUARD_BYTES(GUARD_BYTES), .SLOT_BASE(SLOT_BASE), .NUM_SLOT(NUM_SLOT),
    .SLOT_LAST(SLOT_LAST), .SLOT_SYS(SLOT_SYS)
  ) decode_i (
    .addr_i      (acc_addr_i),
    .in_slot_o   (in_slot),
    .slot_sys_o  (slot_sys),
    .slot_over_o (slot_over),
    .guard_o     (guard),
    .mem_over_o  (mem_over)
  );

  bfc_cause_eval eval_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (acc_valid_i),
    .size_i      (acc_size_i),
    .addr_lo_i   (acc_addr_i[1:0]),
    .write_i     (acc_write_i),
    .priv_i      (acc_priv_i),
    .in_slot_i   (in_slot),
    .slot_sys_i  (slot_sys),
    .slot_over_i (slot_over),
    .guard_i     (guard),
    .mem_over_i  (mem_over),
    .cause_o     (cause)
  );

  bfc_status_reg status_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cause_i    (cause),
    .clr_i      (stat_clr_i),
    .clr_mask_i (stat_clr_mask_i),
    .stat_o     (stat_o),
    .pulse_o    (fault_pulse_o)
  );

  assign acc_err_o = |cause;

  // R8: no error response without a valid access
  a_r8_err_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid_i |-> !acc_err_o);

  // R9: an error response is followed by the fault request
  a_r9_err_then_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err_o |=> fault_pulse_o);

  // R2: misaligned word transfers always draw an error
  a_r2_misaligned_word: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid_i && (acc_size_i == SZ_WORD) && (acc_addr_i[1:0] != 2'b00) |-> acc_err_o);

endmodule

// File: tb/bus_fault_classifier_tb_top.sv
module bus_fault_classifier_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [15:0] addr = '0;
  logic [1:0]  size = '0;
  logic        wr = 1'b0;
  logic        priv = 1'b0;
  logic        err;
  logic        pulse;
  logic [3:0]  stat;
  logic        clr = 1'b0;
  logic [3:0]  clr_mask = '0;

  int unsigned errors = 0;
  int unsigned checks = 0;

  always #5 clk = ~clk;

  bus_fault_classifier #(
    .ADDR_W(16), .CODE_BASE(32'h0000), .CODE_WIN(32'h4000), .CODE_IMPL(32'h3000),
    .DATA_BASE(32'h4000), .DATA_WIN(32'h4000), .DATA_IMPL(32'h1000),
    .GUARD_BYTES(32'h0200), .SLOT_BASE(32'h8000), .NUM_SLOT(4),
    .SLOT_LAST({12'hFFC, 12'h040, 12'h7FC, 12'h010}), .SLOT_SYS(4'b0101)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid_i(valid), .acc_addr_i(addr),
    .acc_size_i(size), .acc_write_i(wr), .acc_priv_i(priv),
    .acc_err_o(err), .fault_pulse_o(pulse), .stat_o(stat),
    .stat_clr_i(clr), .stat_clr_mask_i(clr_mask)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int slot_last(input int blk);
    case (blk)
      0: return 'h010;
      1: return 'h7FC;
      2: return 'h040;
      default: return 'hFFC;
    endcase
  endfunction

  // expected cause bits [2:0]: size, protection, unimplemented
  function automatic logic [3:0] model(input int a, input int s, input bit w, input bit p);
    logic [3:0] c = '0;
    bit in_slot = (a >= 'h8000) && (a < 'hC000);
    int blk = (a - 'h8000) / 4096;
    int ofs = (a - 'h8000) % 4096;
    if (in_slot && s != 2) c[0] = 1'b1;
    if (s == 2 && (a % 4) != 0) c[0] = 1'b1;
    if (w && !p && ((in_slot && (blk == 0 || blk == 2)) || (a >= 'h4000 && a < 'h4200)))
      c[1] = 1'b1;
    if (in_slot && ofs > slot_last(blk)) c[2] = 1'b1;
    if (a >= 'h3000 && a < 'h4000) c[2] = 1'b1;
    if (a >= 'h5000 && a < 'h8000) c[2] = 1'b1;
    return c;
  endfunction

  task automatic drive(input int a, input int s, input bit w, input bit p);
    valid = 1'b1;
    addr  = 16'(a);
    size  = 2'(s);
    wr    = w;
    priv  = p;
  endtask

  // one access from a clean status, then a full clear; two cycles
  task automatic one_access(input int a, input int s, input bit w, input bit p);
    logic [3:0] e = model(a, s, w, p);
    drive(a, s, w, p);
    #1;
    chk(err == (|e), "R8", $sformatf("err @%h s%0d w%0d p%0d", a, s, w, p), err, |e);
    @(negedge clk);
    valid = 1'b0;
    chk(pulse == (|e), "R9", $sformatf("pulse @%h", a), pulse, |e);
    chk(stat[0] == e[0], "R1 R2", $sformatf("size bit @%h s%0d", a, s), stat[0], e[0]);
    chk(stat[1] == e[1], "R3 R4", $sformatf("prot bit @%h w%0d p%0d", a, w, p), stat[1], e[1]);
    chk(stat[2] == e[2], "R5 R6", $sformatf("unimpl bit @%h", a), stat[2], e[2]);
    chk(stat[3] == 1'b0, "R11", $sformatf("overflow @%h", a), stat[3], 0);
    clr = 1'b1;
    clr_mask = 4'hF;
    @(negedge clk);
    clr = 1'b0;
    chk(stat == 4'h0, "R10", "full clear", stat, 0);
  endtask

  int edges [15] = '{'h8010, 'h8014, 'h97FC, 'h9800, 'hA040, 'hA044, 'hBFFC,
                     'h41FC, 'h4200, 'h4FFC, 'h5000, 'h7FFC, 'h2FFC, 'h3000, 'h3FFC};

  initial begin
    #1_900_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(stat == 4'h0, "R12", "status in reset", stat, 0);
    chk(pulse == 1'b0, "R12", "pulse in reset", pulse, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(stat == 4'h0, "R12", "status after reset", stat, 0);
    chk(err == 1'b0, "R8", "err idle", err, 0);

    // R8: error stays low with valid low even on a faulting address
    drive('h8001, 0, 1, 0);
    valid = 1'b0;
    #1;
    chk(err == 1'b0, "R8", "err with valid low", err, 0);
    @(negedge clk);
    chk(stat == 4'h0, "R8", "no record with valid low", stat, 0);

    // sweep over the whole map
    for (int b = 0; b < 256 + 15; b++) begin
      int base = (b < 256) ? b * 256 : edges[b - 256];
      for (int lo = 0; lo < 4; lo++)
        for (int s = 0; s < 3; s++)
          for (int w = 0; w < 2; w++)
            for (int p = 0; p < 2; p++)
              one_access(base + lo, s, w[0], p[0]);
    end

    // R7: user byte write above the last register of a system slot
    drive('hA081, 0, 1, 0);
    #1;
    chk(err == 1'b1, "R7", "multi-cause err", err, 1);
    @(negedge clk);
    valid = 1'b0;
    chk(stat == 4'b0111, "R7", "three causes together", stat, 4'b0111);
    clr = 1'b1; clr_mask = 4'hF;
    @(negedge clk);
    clr = 1'b0;

    // R11: back-to-back faults and same-cycle clears
    drive('h8000, 0, 0, 1);              // size only
    @(negedge clk);
    chk(stat == 4'b0001, "R11", "first fault", stat, 4'b0001);
    chk(pulse == 1'b1, "R9", "first pulse", pulse, 1);
    drive('h4000, 2, 1, 0);              // protection only
    @(negedge clk);
    valid = 1'b0;
    chk(stat == 4'b1011, "R11", "second fault sets overflow", stat, 4'b1011);
    chk(pulse == 1'b1, "R9", "second consecutive pulse", pulse, 1);
    @(negedge clk);
    chk(pulse == 1'b0, "R9", "pulse drops", pulse, 0);
    chk(stat == 4'b1011, "R10", "sticky while idle", stat, 4'b1011);
    clr = 1'b1; clr_mask = 4'b0000;
    @(negedge clk);
    chk(stat == 4'b1011, "R10", "empty mask clears nothing", stat, 4'b1011);
    clr_mask = 4'b0001;
    drive('h3000, 2, 0, 1);              // unimplemented only
    @(negedge clk);
    chk(stat == 4'b1110, "R11", "partial clear plus fault", stat, 4'b1110);
    clr_mask = 4'hF;
    drive('h8000, 0, 0, 1);
    @(negedge clk);
    valid = 1'b0;
    chk(stat == 4'b0001, "R11", "full clear plus fault, no overflow", stat, 4'b0001);
    clr_mask = 4'b0001;
    @(negedge clk);
    clr = 1'b0;
    chk(stat == 4'b0000, "R10", "masked clear empties", stat, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule